// File: doc/BRIEF.md
# Base-Complement Residue Multiplier

This block multiplies two unsigned 8-bit operands by the base-complement method. Each operand is taken away from the base 256. The two complements are multiplied. The low byte of that complement product is the low byte of the answer. The high byte is found without carry propagation across the operand width, as follows:

1. The two operands and the high byte of the complement product are each converted into residues against the pairwise coprime moduli 5, 11 and 14.
2. The three residue vectors are summed one modulus at a time.
3. The sum is rebuilt in binary by the Chinese remainder theorem.
4. The base is removed from the rebuilt value.

The result is exact because a·b = 256·(a + b − 256) + (256 − a)(256 − b). The sum a + b + hi is at most 765, which fits inside the dynamic range 5·11·14 = 770. A zero operand would need a 9-bit complement, so that case skips the arithmetic and returns zero.

The datapath is a three-stage pipeline:

- Stage 1 registers the operands and the complement product.
- Stage 2 registers the residues.
- Stage 3 performs the residue sum and the reconstruction, then registers the result.

A new start may be given on every cycle. Each start produces exactly one done pulse with its own result, and results come out in the order the starts were given. Between results the product output keeps its last value.

Top module: `nikm_mult`

## Requirements
- R1: While rst_n is low and after its release, until the first result is produced, product reads 0 and done reads 0.
- R2: A start sampled high on a rising clock edge makes done high for exactly one cycle, after the third rising edge that counts that sampling edge as the first. On that same cycle, product carries the result for the operands sampled with the start.
- R3: Starts on consecutive cycles are all accepted. Each one yields its own done pulse and its own result, in issue order, one per cycle.
- R4: For operands a and b, both non-zero, the result equals a·b as an unsigned 16-bit value, with the high byte in product[15:8].
- R5: If either operand is 0, the result is 0.
- R6: While done is low, product keeps the value of the last result, or 0 if no result has been produced since reset.
- R7: In a cycle whose result slot holds no start, done stays low.
- R8: For non-zero operands, the low byte of the result is ((256−a)(256−b)) mod 256. The high byte is (a + b + ⌊(256−a)(256−b)/256⌋) mod 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accepts op_a and op_b on this edge |
| op_a | input | 8 | Unsigned multiplicand |
| op_b | input | 8 | Unsigned multiplier |
| product | output | 16 | Last result, held between results |
| done | output | 1 | One-cycle pulse marking a new result on product |

## Verification
Every one of the 65536 operand pairs is streamed back to back. This sweep catches the following faults:

- a wrong modulus or inverse weight in the reconstruction, which spoils the high byte only for some sums;
- a dropped or swapped pipeline slot, which shows up as results leaking into the wrong cycle.

Zero operands are aimed at the bypass. Without it, the wrapped complement of 0 gives a high byte of a or b instead of 0.

The extremes 1·1, 255·255 and 1·255 push the residue sum to its smallest and largest values, where an off-by-base correction shows. Idle gaps confirm that done never fires without a start and that product does not drift between results.

// File: rtl/nikm_pkg.sv
package nikm_pkg;

  localparam int OPW   = 8;    // operand width
  localparam int NMOD  = 3;    // number of moduli
  localparam int RW    = 4;    // bits per residue digit
  localparam int MPROD = 770;  // product of the moduli (dynamic range)
  localparam int SUMW  = 10;   // bits needed to hold any value below MPROD

  typedef logic [NMOD-1:0][RW-1:0] rvec_t;

  // modulus for digit i; pairwise coprime, product MPROD
  function automatic int mod_of(input int i);
    case (i)
      0:       return 5;
      1:       return 11;
      default: return 14;
    endcase
  endfunction

  // binary to residue: add the residue of each set bit's weight,
  // folding back after every step so no wide carry is formed
  function automatic logic [RW-1:0] to_res(input logic [15:0] v, input int m);
    int w;
    int acc;
    w   = 1 % m;
    acc = 0;
    for (int k = 0; k < 16; k++) begin
      if (v[k]) begin
        acc = acc + w;
        if (acc >= m) acc = acc - m;
      end
      w = 2 * w;
      if (w >= m) w = w - m;
    end
    return RW'(acc);
  endfunction

  // modular add of two digits already below m
  function automatic logic [RW-1:0] add_mod(input logic [RW-1:0] x,
                                            input logic [RW-1:0] y,
                                            input int m);
    int s;
    s = int'(x) + int'(y);
    if (s >= m) s = s - m;
    return RW'(s);
  endfunction

  // multiplicative inverse of x modulo m by search (m is small)
  function automatic int mod_inv(input int x, input int m);
    int r;
    r = 1;
    for (int c = 1; c < m; c++)
      if ((x * c) % m == 1) r = c;
    return r;
  endfunction

  // residue to binary through the Chinese remainder theorem
  function automatic logic [SUMW-1:0] crt(input rvec_t r);
    int acc;
    acc = 0;
    for (int i = 0; i < NMOD; i++) begin
      int m;
      int s;
      int t;
      m   = mod_of(i);
      s   = MPROD / m;
      t   = (int'(r[i]) * mod_inv(s % m, m)) % m;
      acc = acc + s * t;
      if (acc >= MPROD) acc = acc - MPROD;
    end
    return SUMW'(acc);
  endfunction

endpackage

// File: rtl/nikm_bin2res.sv
module nikm_bin2res
  import nikm_pkg::*;
#(
  parameter int IW = OPW
) (
  input  logic [IW-1:0] val,
  output rvec_t         res
);

  for (genvar i = 0; i < NMOD; i++) begin : g_digit
    localparam int M = mod_of(i);
    assign res[i] = to_res(16'(val), M);
  end

endmodule

// File: rtl/nikm_res_add.sv
module nikm_res_add
  import nikm_pkg::*;
(
  input  rvec_t x,
  input  rvec_t y,
  input  rvec_t z,
  output rvec_t sum
);

  for (genvar i = 0; i < NMOD; i++) begin : g_lane
    localparam int M = mod_of(i);
    logic [RW-1:0] pair;
    assign pair   = add_mod(x[i], y[i], M);
    assign sum[i] = add_mod(pair, z[i], M);

    // every lane stays a legal digit so the reconstruction is exact
    always_comb begin
      AST_LANE_IN_RANGE: assert (int'(sum[i]) < M); // R4
    end
  end

endmodule

// File: rtl/nikm_res2bin.sv
module nikm_res2bin
  import nikm_pkg::*;
(
  input  rvec_t           res,
  output logic [SUMW-1:0] value
);

  assign value = crt(res);

  // round trip: the rebuilt value must map back onto the same digits
  for (genvar i = 0; i < NMOD; i++) begin : g_chk
    localparam int M = mod_of(i);
    always_comb begin
      AST_CRT_ROUND_TRIP: assert (to_res(16'(value), M) == res[i]); // R4
    end
  end

endmodule

// File: rtl/nikm_mult.sv
module nikm_mult
  import nikm_pkg::*;
#(
  parameter int W = OPW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] product,
  output logic           done
);

  localparam int PW = 2 * W;
  localparam int NCONV = 3;

  // ---------------- stage 1: complements and their product
  logic [W-1:0]  comp_a, comp_b;
  logic [PW-1:0] comp_prod;
  logic          zero_in;
  logic          s1_fire;

  assign comp_a    = W'(0) - op_a;
  assign comp_b    = W'(0) - op_b;
  assign comp_prod = PW'(comp_a) * PW'(comp_b);
  assign zero_in   = (op_a == '0) || (op_b == '0);
  assign s1_fire   = start;

  logic          s1_v, s1_z;
  logic [W-1:0]  s1_a, s1_b;
  logic [PW-1:0] s1_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_z <= 1'b0;
      s1_a <= '0;
      s1_b <= '0;
      s1_p <= '0;
    end else begin
      s1_v <= s1_fire;
      if (s1_fire) begin
        s1_z <= zero_in;
        s1_a <= op_a;
        s1_b <= op_b;
        s1_p <= comp_prod;
      end
    end
  end

  // ---------------- stage 2: binary to residue for three values
  logic [W-1:0] conv_in  [NCONV];
  rvec_t        conv_out [NCONV];

  assign conv_in[0] = s1_a;
  assign conv_in[1] = s1_b;
  assign conv_in[2] = s1_p[PW-1:W];

  for (genvar g = 0; g < NCONV; g++) begin : g_conv
    nikm_bin2res #(.IW(W)) u_cv (
      .val (conv_in[g]),
      .res (conv_out[g])
    );
  end

  logic         s2_v, s2_z;
  rvec_t        s2_ra, s2_rb, s2_rp;
  logic [W-1:0] s2_lo;
  logic         s2_fire;

  assign s2_fire = s1_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_v  <= 1'b0;
      s2_z  <= 1'b0;
      s2_ra <= '0;
      s2_rb <= '0;
      s2_rp <= '0;
      s2_lo <= '0;
    end else begin
      s2_v <= s2_fire;
      if (s2_fire) begin
        s2_z  <= s1_z;
        s2_ra <= conv_out[0];
        s2_rb <= conv_out[1];
        s2_rp <= conv_out[2];
        s2_lo <= s1_p[W-1:0];
      end
    end
  end

  // ---------------- stage 3: residue sum, reconstruction, base removal
  rvec_t           rsum;
  logic [SUMW-1:0] crt_sum;
  logic [SUMW-1:0] hi_full;
  logic [W-1:0]    hi_byte;
  logic            out_fire;

  nikm_res_add u_add (
    .x   (s2_ra),
    .y   (s2_rb),
    .z   (s2_rp),
    .sum (rsum)
  );

  nikm_res2bin u_crt (
    .res   (rsum),
    .value (crt_sum)
  );

  assign hi_full  = crt_sum - SUMW'(1 << W);
  assign hi_byte  = hi_full[W-1:0];
  assign out_fire = s2_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= out_fire;
      if (out_fire)
        product <= s2_z ? '0 : {hi_byte, s2_lo};
    end
  end

  // ---------------- assertions
  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 3)); // R2

  AST_START_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start, 3) && $past(rst_n, 3) && $past(rst_n, 2) && $past(rst_n, 1))
      |-> done); // R3

  AST_ZERO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && s2_z) |=> (product == '0)); // R5

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(product)); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && !s2_z) |-> (hi_full[SUMW-1:W] == '0)); // R4

endmodule

// File: tb/sim_nikm_mult.sv
module sim_nikm_mult;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  op_a, op_b;
  logic [15:0] product;
  logic        done;

  int total = 0;
  int bad   = 0;

  bit          pv [3];
  logic [15:0] pe [3];
  logic [15:0] last_p;

  always #2 clk = ~clk;   // 4 ns period

  nikm_mult u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op_a    (op_a),
    .op_b    (op_b),
    .product (product),
    .done    (done)
  );

  function automatic logic [15:0] model(input logic [7:0] a, input logic [7:0] b);
    if (a == 8'd0 || b == 8'd0) return 16'd0;
    return 16'(a) * 16'(b);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: check what is due now, then drive the next inputs
  task automatic step(input logic st, input logic [7:0] a, input logic [7:0] b,
                      input string tag);
    @(negedge clk);
    if (pv[2]) begin
      chk({tag, " done"}, int'(done), 1);
      chk({tag, " product"}, int'(product), int'(pe[2]));
      last_p = pe[2];
    end else begin
      chk("R7 done without start", int'(done), 0);
      chk("R6 product held", int'(product), int'(last_p));
    end
    pv[2] = pv[1]; pe[2] = pe[1];
    pv[1] = pv[0]; pe[1] = pe[0];
    pv[0] = st;    pe[0] = model(a, b);
    start = st; op_a = a; op_b = b;
  endtask

  task automatic flush(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 8'd0, 8'd0, "R6");
  endtask

  task automatic t_reset;
    rst_n = 1'b0; start = 1'b0; op_a = 8'd0; op_b = 8'd0;
    for (int k = 0; k < 3; k++) pv[k] = 1'b0;
    last_p = 16'd0;
    repeat (3) @(negedge clk);
    chk("R1 product in reset", int'(product), 0);
    chk("R1 done in reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 product after release", int'(product), 0);
    chk("R1 done after release", int'(done), 0);
  endtask

  task automatic t_idle;
    for (int k = 0; k < 5; k++) step(1'b0, 8'd99, 8'd77, "R7");
  endtask

  task automatic t_single;
    step(1'b1, 8'd9, 8'd7, "R2");
    flush(5);
    step(1'b1, 8'd200, 8'd150, "R2");
    flush(4);
  endtask

  task automatic t_zero;
    step(1'b1, 8'd0, 8'd0, "R5");
    step(1'b1, 8'd0, 8'd77, "R5");
    step(1'b1, 8'd200, 8'd0, "R5");
    step(1'b1, 8'd0, 8'd255, "R5");
    flush(4);
  endtask

  task automatic t_corners;
    logic [7:0] ca [6] = '{8'd1, 8'd255, 8'd1,   8'd128, 8'd255, 8'd16};
    logic [7:0] cb [6] = '{8'd1, 8'd255, 8'd255, 8'd128, 8'd2,   8'd16};
    for (int i = 0; i < 6; i++) begin
      int cpa, cpb, cp, ehi, elo;
      step(1'b1, ca[i], cb[i], "R4");
      flush(4);
      cpa = 256 - int'(ca[i]);
      cpb = 256 - int'(cb[i]);
      cp  = cpa * cpb;
      elo = cp % 256;
      ehi = (int'(ca[i]) + int'(cb[i]) + cp / 256) % 256;
      chk("R8 low byte", int'(product[7:0]), elo);
      chk("R8 high byte", int'(product[15:8]), ehi);
    end
  endtask

  task automatic t_stream;
    for (int i = 0; i < 65536; i++)
      step(1'b1, 8'(i >> 8), 8'(i), "R3 R4");
    flush(4);
  endtask

  initial begin
    t_reset;
    t_idle;
    t_single;
    t_zero;
    t_corners;
    t_stream;
    t_idle;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule